// File: doc/BRIEF.md
# Multi-core system timer unit

This block is a timer for a multiprocessor system. One shared 64-bit counter starts at zero and counts up on every clock without ever stopping. Four compare channels watch this counter, and each raises its own interrupt when the count equals its programmed value. Beside it there is one 32-bit countdown timer for each processor. On reaching zero, a countdown timer reloads from its reload value, keeps running, and raises that processor's interrupt.

Software reaches every register through a word-wide register port with a valid/ready handshake. Through this port it sets the compare values, the reload values, the per-timer run bits and the interrupt enables. It also reads and clears the sticky interrupt status. The 64-bit counter is read as two halves, and a read of the low half freezes a copy of the high half so that the two halves go together.

The interrupt vector has one line for each compare channel, then the processor timer lines. A build parameter can instead merge all processor timer lines into a single shared line.

Top module: `mct_timer_unit`

## Requirements
- R1: The global counter is 64 bits wide. After reset it holds 0 and then increases by exactly 1 on every clock. Two low-half reads issued 2 cycles apart return values that differ by 2.
- R2: Channel c (c = 0..3) has a compare low word at byte address 0x10+8c and a compare high word at 0x14+8c. Both words reset to all ones. Status bit c is set on the clock edge at which the counter, before that edge, equals the full 64-bit compare value exactly. No match occurs while the high word differs.
- R3: A write to 0x40+4i loads both the reload value and the current count of processor timer i. While run bit i (bit i of address 0x88) is 1, the count drops by 1 per clock. From 0 the count instead returns to the reload value and sets status bit 4+i, so the timer fires once every reload+1 cycles. The current count is readable at 0x60+4i.
- R4: While run bit i is 0 and no load is written, processor timer i holds its count and sets no status.
- R5: Status is read at 0x84. Writing 1 to a bit there clears that bit. Writing 0 leaves it unchanged. If a set event and a clear fall on the same edge, the bit stays set.
- R6: The enable register at 0x80 uses the same bit positions as status. Each interrupt line is high exactly when its status bit and its enable bit are both 1. Lines 0..3 carry the compare channels and lines 4.. carry the processor timers in processor order.
- R7: With SHARED_LOCAL=1 there are 5 lines. Line 4 is the OR, over all processor timers, of status AND enable, and lines 0..3 are unchanged.
- R8: A read of 0x00 returns bits 31:0 of the counter as it stood in the request cycle. The same read captures bits 63:32 into a holding register, and a read of 0x04 returns that held value.
- R9: After reset all interrupt lines are 0, and status, enables and run bits are 0.
- R10: req_ready is always 1. A read accepted in one cycle has rsp_valid and its data in the next cycle. Writes to read-only or unmapped addresses, or to any address with bits 1:0 non-zero, change no state. Unmapped reads return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Register request present |
| req_ready | output | 1 | Request accepted (always 1) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after the read |
| rsp_rdata | output | 32 | Read data |
| irq_o | output | 4+(SHARED_LOCAL?1:NCPU) | Interrupt lines |

## Verification
Suppose a compare register or a countdown timer holds a wrong value. Its interrupt line then rises at the wrong cycle, and a reference model compares the lines on every clock, so the error appears within one compare match or one reload period. A wrong counter step, or a wrong high-half capture, shows on the next counter read. A status bit that is set or cleared wrongly shows on the same cycle as a change on an enabled line, or on the next status read. The separate build and the shared build run side by side on the same stimulus, so an error in merging the processor timer lines shows on the cycle it happens.

// File: rtl/mct_pkg.sv
package mct_pkg;
  localparam int DW       = 32;
  localparam int AW       = 8;
  localparam int NUM_GCMP = 4;

  localparam logic [AW-1:0] A_CNT_LO    = 8'h00;
  localparam logic [AW-1:0] A_CNT_HI    = 8'h04;
  localparam logic [AW-1:0] A_CMP_BASE  = 8'h10;
  localparam logic [AW-1:0] A_RLD_BASE  = 8'h40;
  localparam logic [AW-1:0] A_LCNT_BASE = 8'h60;
  localparam logic [AW-1:0] A_EN        = 8'h80;
  localparam logic [AW-1:0] A_ST        = 8'h84;
  localparam logic [AW-1:0] A_RUN       = 8'h88;

  // byte address of the idx-th word above base
  function automatic logic [AW-1:0] word_addr(logic [AW-1:0] base, int idx);
    return base + AW'(4 * idx);
  endfunction
endpackage

// File: rtl/mct_global.sv
module mct_global #(
  parameter int HW   = 32,
  parameter int NCMP = 4,
  localparam int CW  = 2 * HW
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NCMP-1:0]          cmp_we,
  input  logic                     cmp_hi,
  input  logic [HW-1:0]            wdata,
  output logic [CW-1:0]            cnt_o,
  output logic [NCMP-1:0][CW-1:0]  cmp_o,
  output logic [NCMP-1:0]          match_o
);
  logic [CW-1:0] cnt_q;

  function automatic logic [CW-1:0] count_step(logic [CW-1:0] v);
    return v + CW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= count_step(cnt_q);
  end
  assign cnt_o = cnt_q;

  for (genvar ch = 0; ch < NCMP; ch++) begin : g_cmp
    logic [CW-1:0] cmp_q;
    always_ff @(posedge clk) begin
      if (rst) cmp_q <= '1;
      else if (cmp_we[ch]) begin
        if (cmp_hi) cmp_q[CW-1:HW] <= wdata;
        else        cmp_q[HW-1:0]  <= wdata;
      end
    end
    assign cmp_o[ch]   = cmp_q;
    assign match_o[ch] = (cnt_q == cmp_q);
  end

  p_free_run_r1: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> cnt_q == $past(cnt_q) + CW'(1));
endmodule

// File: rtl/mct_local.sv
module mct_local #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_we,
  input  logic [W-1:0] load_val,
  input  logic         run,
  output logic         expire_o,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] reload_o
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] reload_q;

  function automatic logic [W-1:0] step_down(logic [W-1:0] c, logic [W-1:0] r);
    return (c == '0) ? r : c - W'(1);
  endfunction

  assign expire_o = run && !load_we && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      reload_q <= '0;
    end else if (load_we) begin
      cnt_q    <= load_val;
      reload_q <= load_val;
    end else if (run) begin
      cnt_q    <= step_down(cnt_q, reload_q);
    end
  end

  assign cnt_o    = cnt_q;
  assign reload_o = reload_q;

  p_reload_on_expiry_r3: assert property (@(posedge clk) disable iff (rst)
    expire_o |=> cnt_q == $past(reload_q));
  p_hold_when_stopped_r4: assert property (@(posedge clk) disable iff (rst)
    (!run && !load_we) |=> $stable(cnt_q));
endmodule

// File: rtl/mct_irq.sv
module mct_irq #(
  parameter int NB = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NB-1:0] set_i,
  input  logic [NB-1:0] clr_i,
  input  logic          en_we,
  input  logic [NB-1:0] en_val,
  output logic [NB-1:0] st_o,
  output logic [NB-1:0] en_o
);
  logic [NB-1:0] st_q;
  logic [NB-1:0] en_q;

  function automatic logic [NB-1:0] sticky_next(logic [NB-1:0] s, logic [NB-1:0] set,
                                                logic [NB-1:0] clr);
    return (s & ~clr) | set;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= '0;
      en_q <= '0;
    end else begin
      st_q <= sticky_next(st_q, set_i, clr_i);
      if (en_we) en_q <= en_val;
    end
  end

  assign st_o = st_q;
  assign en_o = en_q;

  for (genvar b = 0; b < NB; b++) begin : g_chk
    p_set_wins_r5: assert property (@(posedge clk) disable iff (rst)
      set_i[b] |=> st_q[b]);
    p_w1c_r5: assert property (@(posedge clk) disable iff (rst)
      (clr_i[b] && !set_i[b]) |=> !st_q[b]);
  end
endmodule

// File: rtl/mct_timer_unit.sv
module mct_timer_unit
  import mct_pkg::*;
#(
  parameter int NCPU         = 2,
  parameter bit SHARED_LOCAL = 1'b0,
  localparam int NB          = NUM_GCMP + NCPU,
  localparam int NOUT        = NUM_GCMP + (SHARED_LOCAL ? 1 : NCPU)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic            req_write,
  input  logic [AW-1:0]   req_addr,
  input  logic [DW-1:0]   req_wdata,
  output logic            rsp_valid,
  output logic [DW-1:0]   rsp_rdata,
  output logic [NOUT-1:0] irq_o
);
  localparam int CW = 2 * DW;

  logic wr, rd;
  assign req_ready = 1'b1;
  assign wr = req_valid & req_write;
  assign rd = req_valid & ~req_write;

  logic unused_wdata;
  assign unused_wdata = ^req_wdata[DW-1:NB];

  // write decode
  logic [NUM_GCMP-1:0] cmp_we;
  logic [NCPU-1:0]     load_we;
  logic                en_we, st_we, run_we;
  always_comb begin
    for (int ch = 0; ch < NUM_GCMP; ch++)
      cmp_we[ch] = wr && (req_addr == word_addr(A_CMP_BASE, 2*ch) ||
                          req_addr == word_addr(A_CMP_BASE, 2*ch + 1));
    for (int i = 0; i < NCPU; i++)
      load_we[i] = wr && (req_addr == word_addr(A_RLD_BASE, i));
  end
  assign en_we  = wr && (req_addr == A_EN);
  assign st_we  = wr && (req_addr == A_ST);
  assign run_we = wr && (req_addr == A_RUN);

  // global counter and compares
  logic [CW-1:0]                gcnt;
  logic [NUM_GCMP-1:0][CW-1:0]  gcmp;
  logic [NUM_GCMP-1:0]          gmatch;
  mct_global #(.HW(DW), .NCMP(NUM_GCMP)) u_global (
    .clk(clk), .rst(rst), .cmp_we(cmp_we), .cmp_hi(req_addr[2]),
    .wdata(req_wdata), .cnt_o(gcnt), .cmp_o(gcmp), .match_o(gmatch)
  );

  // per-processor countdown timers
  logic [NCPU-1:0]         run_q;
  logic [NCPU-1:0]         lexpire;
  logic [NCPU-1:0][DW-1:0] lcnt;
  logic [NCPU-1:0][DW-1:0] lrld;

  always_ff @(posedge clk) begin
    if (rst)         run_q <= '0;
    else if (run_we) run_q <= req_wdata[NCPU-1:0];
  end

  for (genvar i = 0; i < NCPU; i++) begin : g_local
    mct_local #(.W(DW)) u_local (
      .clk(clk), .rst(rst), .load_we(load_we[i]), .load_val(req_wdata),
      .run(run_q[i]), .expire_o(lexpire[i]), .cnt_o(lcnt[i]), .reload_o(lrld[i])
    );
  end

  // interrupt status and enables
  logic [NB-1:0] st, en, clr;
  assign clr = st_we ? req_wdata[NB-1:0] : '0;
  mct_irq #(.NB(NB)) u_irq (
    .clk(clk), .rst(rst), .set_i({lexpire, gmatch}), .clr_i(clr),
    .en_we(en_we), .en_val(req_wdata[NB-1:0]), .st_o(st), .en_o(en)
  );

  logic [NB-1:0] active;
  assign active = st & en;
  if (SHARED_LOCAL) begin : g_shared
    assign irq_o = {|active[NB-1:NUM_GCMP], active[NUM_GCMP-1:0]};
  end else begin : g_separate
    assign irq_o = active;
  end

  // read path
  logic [DW-1:0] hi_q;
  logic [DW-1:0] rdata_d;
  always_comb begin
    rdata_d = '0;
    if (req_addr == A_CNT_LO) rdata_d = gcnt[DW-1:0];
    if (req_addr == A_CNT_HI) rdata_d = hi_q;
    if (req_addr == A_EN)     rdata_d = DW'(en);
    if (req_addr == A_ST)     rdata_d = DW'(st);
    if (req_addr == A_RUN)    rdata_d = DW'(run_q);
    for (int ch = 0; ch < NUM_GCMP; ch++) begin
      if (req_addr == word_addr(A_CMP_BASE, 2*ch))     rdata_d = gcmp[ch][DW-1:0];
      if (req_addr == word_addr(A_CMP_BASE, 2*ch + 1)) rdata_d = gcmp[ch][CW-1:DW];
    end
    for (int i = 0; i < NCPU; i++) begin
      if (req_addr == word_addr(A_RLD_BASE, i))  rdata_d = lrld[i];
      if (req_addr == word_addr(A_LCNT_BASE, i)) rdata_d = lcnt[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      hi_q      <= '0;
    end else begin
      rsp_valid <= rd;
      if (rd) rsp_rdata <= rdata_d;
      if (rd && req_addr == A_CNT_LO) hi_q <= gcnt[CW-1:DW];
    end
  end

  p_read_latency_r10: assert property (@(posedge clk) disable iff (rst)
    rd |=> rsp_valid);
  p_hi_capture_r8: assert property (@(posedge clk) disable iff (rst)
    (rd && req_addr == A_CNT_LO) |=> hi_q == $past(gcnt[CW-1:DW]));
endmodule

// File: tb/tb_mct_timer_unit.sv
`timescale 1ns/1ps
module tb_mct_timer_unit;
  localparam int NCPU = 2;
  localparam int NB   = 4 + NCPU;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic req_ready, rsp_valid, req_ready_s, rsp_valid_s;
  logic [31:0] rsp_rdata, rsp_rdata_s;
  logic [NB-1:0] irq;
  logic [4:0] irq_s;

  always #2.5 clk = ~clk;

  mct_timer_unit #(.NCPU(NCPU), .SHARED_LOCAL(1'b0)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .irq_o(irq));

  mct_timer_unit #(.NCPU(NCPU), .SHARED_LOCAL(1'b1)) dut_shared (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready_s),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid_s), .rsp_rdata(rsp_rdata_s), .irq_o(irq_s));

  int tests = 0, fails = 0, cyc = 0;
  bit done = 0;
  string cur_tag = "R10", m_tag = "R10";
  logic [31:0] rd_val;

  // behavioural reference model
  logic [63:0] m_g;
  logic [63:0] m_cmp [4];
  logic [31:0] m_lc [NCPU];
  logic [31:0] m_rl [NCPU];
  logic [NB-1:0] m_st, m_en;
  logic [NCPU-1:0] m_run;
  logic [31:0] m_hi, m_rd;
  bit m_rv;

  always @(posedge clk) begin
    logic [NB-1:0] s, c;
    if (rst) begin
      m_g = 0; m_st = 0; m_en = 0; m_run = 0; m_hi = 0; m_rd = 0; m_rv = 0;
      for (int k = 0; k < 4; k++) m_cmp[k] = '1;
      for (int k = 0; k < NCPU; k++) begin m_lc[k] = 0; m_rl[k] = 0; end
    end else begin
      m_rv = req_valid && !req_write;
      if (m_rv) begin
        m_tag = cur_tag;
        m_rd = 0;
        case (req_addr)
          8'h00: begin m_rd = m_g[31:0]; m_hi = m_g[63:32]; end
          8'h04: m_rd = m_hi;
          8'h80: m_rd = 32'(m_en);
          8'h84: m_rd = 32'(m_st);
          8'h88: m_rd = 32'(m_run);
          default: ;
        endcase
        for (int k = 0; k < 4; k++) begin
          if (req_addr == 8'(16 + 8*k)) m_rd = m_cmp[k][31:0];
          if (req_addr == 8'(20 + 8*k)) m_rd = m_cmp[k][63:32];
        end
        for (int k = 0; k < NCPU; k++) begin
          if (req_addr == 8'(64 + 4*k)) m_rd = m_rl[k];
          if (req_addr == 8'(96 + 4*k)) m_rd = m_lc[k];
        end
      end
      s = 0; c = 0;
      for (int k = 0; k < 4; k++) if (m_g == m_cmp[k]) s[k] = 1;
      for (int k = 0; k < NCPU; k++) begin
        if (req_valid && req_write && req_addr == 8'(64 + 4*k)) begin
          m_lc[k] = req_wdata; m_rl[k] = req_wdata;
        end else if (m_run[k]) begin
          if (m_lc[k] == 0) begin s[4+k] = 1; m_lc[k] = m_rl[k]; end
          else m_lc[k] = m_lc[k] - 1;
        end
      end
      if (req_valid && req_write) begin
        if (req_addr == 8'h80) m_en = req_wdata[NB-1:0];
        if (req_addr == 8'h84) c = req_wdata[NB-1:0];
        if (req_addr == 8'h88) m_run = req_wdata[NCPU-1:0];
        for (int k = 0; k < 4; k++) begin
          if (req_addr == 8'(16 + 8*k)) m_cmp[k][31:0]  = req_wdata;
          if (req_addr == 8'(20 + 8*k)) m_cmp[k][63:32] = req_wdata;
        end
      end
      m_st = (m_st & ~c) | s;
      m_g = m_g + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    logic [NB-1:0] e;
    logic [4:0] es;
    cyc++;
    if (!rst) begin
      e  = m_st & m_en;
      es = {|e[NB-1:4], e[3:0]};
      chk(irq == e, "R6", "irq lines", longint'(irq), longint'(e));
      chk(irq_s == es, "R7", "shared irq lines", longint'(irq_s), longint'(es));
      chk(req_ready && req_ready_s, "R10", "ready", longint'(req_ready), 1);
      chk(rsp_valid == m_rv, "R10", "rsp_valid", longint'(rsp_valid), longint'(m_rv));
      if (m_rv) begin
        chk(rsp_rdata == m_rd, m_tag, "read data", longint'(rsp_rdata), longint'(m_rd));
        chk(rsp_rdata_s == m_rd, m_tag, "shared read data", longint'(rsp_rdata_s),
            longint'(m_rd));
      end
    end
    if (cyc > 50000 && !done) begin
      chk(0, "R10", "watchdog expired", cyc, 50000);
      summary();
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  task automatic rd(input logic [7:0] a, input string tag);
    cur_tag = tag;
    req_valid = 1; req_write = 0; req_addr = a;
    @(negedge clk);
    req_valid = 0;
    #1 rd_val = rsp_rdata;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [31:0] a, b;
    idle(4);
    rst = 0;
    chk(irq == 0 && irq_s == 0, "R9", "irq after reset", longint'(irq), 0);
    rd(8'h84, "R9");
    chk(rd_val == 0, "R9", "status after reset", longint'(rd_val), 0);
    rd(8'h10, "R2");
    chk(rd_val == 32'hFFFF_FFFF, "R2", "compare reset", longint'(rd_val), 32'hFFFF_FFFF);

    // compares: ch3 has a non-zero high word and must not match
    wr(8'h14, 0); wr(8'h10, 60);
    wr(8'h1C, 0); wr(8'h18, 90);
    wr(8'h24, 0); wr(8'h20, 91);
    wr(8'h2C, 1); wr(8'h28, 70);
    wr(8'h80, 32'h3F);
    wr(8'h40, 7); wr(8'h44, 3);
    wr(8'h88, 3);
    idle(40);
    wr(8'h84, 32'h3F);
    idle(30);
    rd(8'h84, "R5");
    chk(rd_val[3] == 0, "R2", "channel 3 high word blocks match", longint'(rd_val[3]), 0);

    rd(8'h00, "R1"); a = rd_val;
    rd(8'h00, "R1"); b = rd_val;
    chk(b - a == 2, "R1", "counter step", longint'(b - a), 2);
    rd(8'h04, "R8");
    chk(rd_val == 0, "R8", "latched high half", longint'(rd_val), 0);
    rd(8'h28, "R2"); rd(8'h2C, "R2");
    rd(8'h40, "R3"); rd(8'h60, "R3"); rd(8'h64, "R3");

    // stop timer 1 and confirm its count holds
    wr(8'h88, 1);
    rd(8'h64, "R4"); a = rd_val;
    idle(9);
    rd(8'h64, "R4"); b = rd_val;
    chk(a == b, "R4", "stopped count holds", longint'(b), longint'(a));
    wr(8'h84, 32'h20);
    idle(10);
    rd(8'h84, "R4");
    chk(rd_val[5] == 0, "R4", "stopped timer sets no status", longint'(rd_val[5]), 0);

    // enable only timer 0
    wr(8'h80, 32'h10);
    idle(20);

    // writes that must be ignored
    wr(8'h00, 32'hDEAD); wr(8'h41, 0); wr(8'hF0, 32'h55);
    rd(8'h00, "R10"); rd(8'h40, "R10");
    chk(rd_val == 7, "R10", "misaligned write ignored", longint'(rd_val), 7);
    rd(8'hF0, "R10");

    // clear repeatedly while timers expire
    wr(8'h80, 32'h3F); wr(8'h88, 3); wr(8'h44, 0);
    for (int k = 0; k < 12; k++) wr(8'h84, 32'h30);
    rd(8'h84, "R5");
    idle(30);
    rd(8'h80, "R6"); rd(8'h88, "R3");
    wr(8'h88, 0);
    idle(5);
    done = 1;
    summary();
  end
endmodule